// File: doc/BRIEF.md
# Synthesizer Frequency Configuration Port

This block holds the frequency settings of a clock synthesizer: a 7-bit loop multiplier, a 2-bit output divide code and a 3-bit test-select field. Settings arrive by two routes. The first is a three-wire serial port made of a data line, a shift clock and a load strobe. The second is a parallel word that carries the multiplier and the divide code, together with its own load strobe. The latched fields drive the downstream feedback counter, the output divider and the test multiplexer. A decoded divide ratio is also provided as a one-hot value.

All strobes are sampled on the block clock, and their edges are found by comparing each sample with the one taken before it. A rising edge of the shift clock moves one bit into a 12-bit shift register. A falling edge of the serial load strobe copies that register into the latches. The parallel route has priority. While its strobe is low, the latches follow the parallel inputs. On the strobe's rising edge the last values are held. A power-up sequence keeps the parallel strobe low and then releases it, which commits the parallel word.

Top module: `synth_cfg_port`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become M = 7'h7F, N = 2'b00, T = 3'b000 and divide ratio = 4'b0001 after that edge.
- R2: The serial word is 12 bits, shifted MSB first, ordered T[2:0], N[1:0], M[6:0]. After 12 shift-clock rising edges and a commit, the first bit shifted appears as T[2] and the last bit as M[0].
- R3: A high-to-low transition of the serial load strobe commits the shift register to T, N and M, provided the parallel strobe is high and not rising in that sample. A low-to-high transition of the serial load strobe changes nothing.
- R4: Shifting does not change the outputs. The outputs stay the same until a load event commits them.
- R5: On the low-to-high transition of the parallel strobe, M and N take the parallel inputs and T keeps its value. After that, while the strobe stays high, changes on the parallel inputs have no effect on the outputs.
- R6: While the parallel strobe is low, M and N follow the parallel inputs one clock later, T keeps its value, and serial load strobes have no effect.
- R7: If a parallel rising edge and a serial falling edge fall in the same sample, the parallel values are loaded. The shift register keeps its contents, so a later serial commit still loads them.
- R8: The divide ratio output is one-hot and equals 1 << N: code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R9: A shift-clock high that lasts several clock cycles shifts only once. When more than 12 bits are shifted, only the last 12 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock; each rising transition shifts one bit |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial load strobe; a falling transition commits the shift register |
| par_load_i | input | 1 | Parallel load strobe; low means follow the inputs, a rising transition captures them |
| par_m_i | input | 7 | Parallel loop multiplier |
| par_n_i | input | 2 | Parallel output divide code |
| m_o | output | 7 | Latched loop multiplier |
| n_o | output | 2 | Latched output divide code |
| t_o | output | 3 | Latched test-select field |
| div_ratio_o | output | 4 | One-hot output divide ratio, 1 << N |

## Verification
The assertions take for granted four things about the inputs:
- every strobe is already synchronous to `clk`;
- every high or low level lasts at least one clock sample, so each transition is seen exactly once;
- the serial data bit is stable in the sample where the shift clock rises;
- the parallel strobe is low while `rst` is asserted.

The stimulus drives all inputs on the falling edge of `clk` and holds every strobe level for at least one full cycle. It lowers the parallel strobe before releasing reset. It reads the outputs one falling edge after the rising edge that acts on them.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int M_W    = 7;
    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int SR_W   = T_W + N_W + M_W;
    localparam int DIV_W  = 2 ** N_W;

    // strobe vector layout and the edge each bit is watched for (1 = rise)
    localparam int STROBES  = 3;
    localparam int IDX_SCLK = 0;
    localparam int IDX_SLD  = 1;
    localparam int IDX_PLD  = 2;
    localparam logic [STROBES-1:0] STROBE_POL = 3'b101;

    // packed order matches the serial word: first bit shifted lands in t[T_W-1]
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_PAR,
        SRC_SER
    } src_e;

    localparam cfg_t CFG_RESET = '{t: '0, n: '0, m: '1};

    function automatic logic [DIV_W-1:0] div_ratio(input logic [N_W-1:0] code);
        return DIV_W'(1) << code;
    endfunction

endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
    parameter int            W   = 3,
    parameter logic [W-1:0]  POL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] edge_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (POL[i]) begin : g_rise
            assign edge_o[i] = sig_i[i] & ~prev_q[i];
        end else begin : g_fall
            assign edge_o[i] = ~sig_i[i] & prev_q[i];
        end
    end

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    always_ff @(posedge clk) begin
        if (rst)             word_o <= '0;
        else if (shift_en_i) word_o <= {word_o[W-2:0], bit_i};
    end

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en_i |=> $stable(word_o)); // R9

    AST_SHIFT_NEWBIT: assert property (@(posedge clk) disable iff (rst)
        shift_en_i |=> (word_o[0] == $past(bit_i))); // R2

endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
    import cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [M_W-1:0]  par_m_i,
    input  logic [N_W-1:0]  par_n_i,
    input  logic            pld_level_i,
    input  logic            pld_rise_i,
    input  logic            sld_fall_i,
    input  logic [SR_W-1:0] sr_word_i,
    output cfg_t            cfg_q
);

    src_e src;

    always_comb begin
        if (!pld_level_i || pld_rise_i) src = SRC_PAR;
        else if (sld_fall_i)            src = SRC_SER;
        else                            src = SRC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            case (src)
                SRC_PAR: begin
                    cfg_q.m <= par_m_i;
                    cfg_q.n <= par_n_i;
                end
                SRC_SER: cfg_q <= cfg_t'(sr_word_i);
                default: cfg_q <= cfg_q;
            endcase
        end
    end

    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !pld_level_i |=> (cfg_q.m == $past(par_m_i) && cfg_q.n == $past(par_n_i))); // R6

    AST_PAR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        pld_rise_i |=> (cfg_q.m == $past(par_m_i) && cfg_q.n == $past(par_n_i))); // R5

    AST_PAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (pld_rise_i && sld_fall_i) |=> $stable(cfg_q.t)); // R7

    AST_T_KEEP: assert property (@(posedge clk) disable iff (rst)
        !pld_level_i |=> $stable(cfg_q.t)); // R6

    AST_SER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (pld_level_i && !pld_rise_i && sld_fall_i) |=> (cfg_q == cfg_t'($past(sr_word_i)))); // R3

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_data_i,
    input  logic             ser_load_i,
    input  logic             par_load_i,
    input  logic [M_W-1:0]   par_m_i,
    input  logic [N_W-1:0]   par_n_i,
    output logic [M_W-1:0]   m_o,
    output logic [N_W-1:0]   n_o,
    output logic [T_W-1:0]   t_o,
    output logic [DIV_W-1:0] div_ratio_o
);

    logic [STROBES-1:0] strobes;
    logic [STROBES-1:0] edges;
    logic [SR_W-1:0]    sr_word;
    cfg_t               cfg_q;

    assign strobes[IDX_SCLK] = ser_clk_i;
    assign strobes[IDX_SLD]  = ser_load_i;
    assign strobes[IDX_PLD]  = par_load_i;

    cfg_edge_det #(
        .W   (STROBES),
        .POL (STROBE_POL)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (strobes),
        .edge_o (edges)
    );

    cfg_shift_reg #(
        .W (SR_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .shift_en_i (edges[IDX_SCLK]),
        .bit_i      (ser_data_i),
        .word_o     (sr_word)
    );

    cfg_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .par_m_i     (par_m_i),
        .par_n_i     (par_n_i),
        .pld_level_i (par_load_i),
        .pld_rise_i  (edges[IDX_PLD]),
        .sld_fall_i  (edges[IDX_SLD]),
        .sr_word_i   (sr_word),
        .cfg_q       (cfg_q)
    );

    assign m_o         = cfg_q.m;
    assign n_o         = cfg_q.n;
    assign t_o         = cfg_q.t;
    assign div_ratio_o = div_ratio(cfg_q.n);

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (par_load_i && !edges[IDX_PLD] && !edges[IDX_SLD])
            |=> ($stable(m_o) && $stable(n_o) && $stable(t_o))); // R4

    AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $onehot(div_ratio_o)); // R8

endmodule

// File: tb/tb_synth_cfg_port.sv
module tb_synth_cfg_port;

    logic       clk = 1'b0;
    logic       rst;
    logic       sclk, sdata, sld, pld;
    logic [6:0] pm;
    logic [1:0] pn;
    logic [6:0] m_o;
    logic [1:0] n_o;
    logic [2:0] t_o;
    logic [3:0] div_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int em, en, et;

    always #2.5 clk = ~clk;

    synth_cfg_port dut (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdata),
        .ser_load_i(sld), .par_load_i(pld), .par_m_i(pm), .par_n_i(pn),
        .m_o(m_o), .n_o(n_o), .t_o(t_o), .div_ratio_o(div_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " M"}, int'(m_o), em);
        chk({req, " N"}, int'(n_o), en);
        chk({req, " T"}, int'(t_o), et);
        chk({req, " div"}, int'(div_o), 1 << en);
    endtask

    task automatic shift_bit(input logic b, input int hold);
        @(negedge clk);
        sdata = b;
        sclk  = 1'b1;
        for (int h = 1; h < hold; h++) @(negedge clk);
        @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic shift_word(input int t, input int n, input int m, input int hold);
        int w;
        w = (t << 9) | (n << 7) | m;
        for (int i = 11; i >= 0; i--) shift_bit(w[i], hold);
    endtask

    task automatic serial_commit(input string req);
        @(negedge clk);
        sld = 1'b1;
        @(negedge clk);
        chk_all({req, " rise-no-effect"});
        sld = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int mlist[6];
        mlist = '{0, 1, 85, 42, 127, 100};
        rst = 1'b1; sclk = 0; sdata = 0; sld = 0; pld = 0;
        pm = 7'h12; pn = 2'b01;
        repeat (3) @(negedge clk);
        em = 'h7F; en = 0; et = 0;
        chk_all("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        em = 'h12; en = 1; et = 0;
        chk_all("R6 follow after reset");

        // R6 / R8: parallel follow sweep over every M and N
        for (int mm = 0; mm < 128; mm++) begin
            for (int nn = 0; nn < 4; nn++) begin
                pm = 7'(mm); pn = 2'(nn);
                @(negedge clk);
                em = mm; en = nn;
                chk_all("R6 R8 follow");
            end
        end

        // R5: capture on rising edge, then inputs ignored
        pm = 7'h3C; pn = 2'd2;
        @(negedge clk);
        pld = 1'b1;
        @(negedge clk);
        em = 'h3C; en = 2;
        chk_all("R5 capture");
        pm = 7'h01; pn = 2'd3;
        @(negedge clk);
        @(negedge clk);
        chk_all("R5 inputs ignored");

        // R2 / R3 / R4 / R8: serial sweep
        for (int t = 0; t < 8; t++) begin
            for (int n = 0; n < 4; n++) begin
                for (int k = 0; k < 6; k++) begin
                    shift_word(t, n, mlist[k], 1);
                    @(negedge clk);
                    chk_all("R4 no change while shifting");
                    serial_commit("R3");
                    em = mlist[k]; en = n; et = t;
                    chk_all("R2 R3 R8 serial commit");
                end
            end
        end

        // R9: long shift-clock highs and 15 bits, last 12 kept
        shift_bit(1'b1, 3); shift_bit(1'b0, 3); shift_bit(1'b1, 3);
        shift_word(5, 1, 'h2B, 3);
        @(negedge clk);
        chk_all("R9 R4 no change while shifting");
        serial_commit("R9");
        em = 'h2B; en = 1; et = 5;
        chk_all("R9 long highs and overlength");

        // R6: serial load ignored while parallel strobe low
        shift_word(2, 3, 'h66, 1);
        @(negedge clk);
        pld = 1'b0; pm = 7'h11; pn = 2'd1;
        @(negedge clk);
        em = 'h11; en = 1;
        chk_all("R6 follow");
        serial_commit("R6");
        chk_all("R6 serial ignored");

        // R7: simultaneous parallel rise and serial fall
        pm = 7'h22; pn = 2'd2;
        sld = 1'b1;
        @(negedge clk);
        em = 'h22; en = 2;
        chk_all("R7 setup");
        pld = 1'b1; sld = 1'b0;
        @(negedge clk);
        chk_all("R7 parallel wins");
        serial_commit("R7");
        em = 'h66; en = 3; et = 2;
        chk_all("R7 shift register kept");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule